// File: doc/BRIEF.md
# Transmit Descriptor Poll Engine

This block is the transmit half of a descriptor-driven network controller. Software builds a ring of 16-byte descriptors in memory, programs the ring base address, and then writes a poll byte. The engine walks the ring through a word-wide memory port. For each descriptor it reads the status word and the buffer address, streams the buffer bytes onto a byte-wide valid/ready frame interface, and writes the status word back with the ownership flag cleared.

A descriptor is four 32-bit words. Offset 0 is the status word, offset 4 is a VLAN tag that this engine never reads, and offsets 8 and 12 hold the low and high halves of the buffer byte address. In the status word:

- bit 31 is the hardware-ownership flag;
- bit 30 means "last slot, wrap to the ring base";
- bits 29 and 28 mark the first and the last segment of a frame;
- bits 15:0 hold the byte count.

Software pads short frames itself, so a count of at least 60 is expected, but the engine sends whatever count it finds. Walking stops at the first descriptor that hardware does not own. The engine then waits for the next poll and resumes at that same slot.

Top module: `txdesc_poll_engine`

## Requirements
- R1: After reset, `mem_req`, `tx_valid`, `desc_done` and `busy` are low.
- R2: A poll write starts fetching only when bit 6 of `poll_data` is 1. A poll byte with bit 6 clear causes no memory request and leaves `busy` low.
- R3: If the status word fetched (descriptor offset 0) has bit 31 clear, the engine emits no byte, writes nothing back and returns to idle. The next poll re-reads that same descriptor.
- R4: For an owned descriptor, the engine emits exactly the byte count in status bits 15:0. The bytes come from consecutive addresses starting at the 64-bit buffer address formed from offset 12 (high) and offset 8 (low). The buffer may start at any byte alignment. Memory is little-endian: byte address a sits in bits 8*(a mod 4)+7 : 8*(a mod 4) of the word at a with its two low bits cleared.
- R5: `tx_first` is high on the first byte of a descriptor exactly when status bit 29 is 1. `tx_last` is high on its final byte exactly when status bit 28 is 1. Both are low on all other bytes.
- R6: When a descriptor is finished, the engine writes its status word back to descriptor offset 0. Bit 31 is cleared and every other bit is unchanged. No other descriptor word is written.
- R7: `desc_done` is high for exactly one cycle, in the cycle after the write-back is acknowledged, and at no other time.
- R8: After a descriptor, the next one is read at the current address plus 16. If status bit 30 was 1, the next one is read at the ring base instead.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` keeps its value in the next cycle.
- R10: A descriptor with a byte count of 0 emits no byte but is still written back and reported done.
- R11: A base write with `base_sel`=0 sets base bits 31:0, and with `base_sel`=1 sets bits 63:32. While the engine is idle, a base write also moves the next-fetch address to the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_we | input | 1 | Ring base register write strobe |
| base_sel | input | 1 | 0 = low half, 1 = high half of the ring base |
| base_wdata | input | 32 | Ring base write data |
| poll_we | input | 1 | Poll register write strobe |
| poll_data | input | 8 | Poll byte; bit 6 starts fetching |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the 32-bit word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes in this cycle |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | `tx_data` is valid |
| tx_first | output | 1 | First byte of a first-segment descriptor |
| tx_last | output | 1 | Final byte of a last-segment descriptor |
| tx_ready | input | 1 | Sink accepts the byte |
| desc_done | output | 1 | One-cycle pulse per written-back descriptor |
| busy | output | 1 | Engine is walking the ring |

## Verification
A wrong byte counter or lane pointer shows up on `tx_data` at the first misplaced byte. It also shows as a short or long frame once the engine goes idle. A wrong next-descriptor address shows within one descriptor: a status word is cleared in the wrong slot, or a slot past the wrap point gets touched. A wrong ownership decision shows the same way, or as bytes sent out of a slot the engine does not own. Flag and pulse timing errors (`tx_first`, `tx_last`, `desc_done`) appear on the very byte or cycle concerned. The bench sweeps every buffer alignment against byte counts from 0 to 9 and then runs multi-descriptor rings under random backpressure.

// File: rtl/txp_pkg.sv
package txp_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned OWN_BIT    = 31;
  localparam int unsigned WRAP_BIT   = 30;
  localparam int unsigned FIRST_BIT  = 29;
  localparam int unsigned LAST_BIT   = 28;
  localparam int unsigned DESC_BYTES = 16;
  localparam int unsigned OFS_BUF_LO = 8;
  localparam int unsigned OFS_BUF_HI = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STS,
    ST_BLO,
    ST_BHI,
    ST_DAT,
    ST_SEND,
    ST_WB
  } txp_state_e;
endpackage

// File: rtl/txp_ring_base.sv
module txp_ring_base #(
  parameter int unsigned ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              sel,
  input  logic [31:0]       wdata,
  output logic [ADDR_W-1:0] base,
  output logic              upd
);
  logic [31:0] lo_q, lo_d, hi_q, hi_d;
  logic        upd_q;

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (we && !sel) lo_d = wdata;
    if (we && sel)  hi_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      upd_q <= 1'b0;
    end else begin
      if (we) begin
        lo_q <= lo_d;
        hi_q <= hi_d;
      end
      upd_q <= we;
    end
  end

  assign base = ADDR_W'({hi_q, lo_q});
  assign upd  = upd_q;
endmodule

// File: rtl/txp_lane_sel.sv
module txp_lane_sel #(
  parameter int unsigned LANES = 4
) (
  input  logic [8*LANES-1:0]         word,
  input  logic [$clog2(LANES)-1:0]   sel,
  output logic [7:0]                 lane_byte
);
  logic [7:0] lanes [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes[g] = word[8*g +: 8];
  end

  assign lane_byte = lanes[sel];
endmodule

// File: rtl/txp_ctrl.sv
module txp_ctrl
  import txp_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              poll_go,
  input  logic [ADDR_W-1:0] base,
  input  logic              base_upd,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  output logic [31:0]       cur_word,
  output logic [1:0]        cur_lane,
  output logic              tx_valid,
  output logic              tx_first,
  output logic              tx_last,
  input  logic              tx_ready,
  output logic              desc_done,
  output logic              busy
);
  localparam logic [ADDR_W-1:0] STEP   = ADDR_W'(DESC_BYTES);
  localparam logic [ADDR_W-1:0] OFS_LO = ADDR_W'(OFS_BUF_LO);
  localparam logic [ADDR_W-1:0] OFS_HI = ADDR_W'(OFS_BUF_HI);
  localparam logic [31:0]       OWN_CLR = ~(32'h1 << OWN_BIT);

  txp_state_e        state_q, state_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [ADDR_W-1:0] buf_q, buf_d;
  logic [31:0]       stat_q, stat_d;
  logic [31:0]       word_q, word_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic              first_q, first_d;
  logic              done_q, done_d;

  always_comb begin
    state_d   = state_q;
    ptr_d     = ptr_q;
    buf_d     = buf_q;
    stat_d    = stat_q;
    word_d    = word_q;
    rem_d     = rem_q;
    first_d   = first_q;
    done_d    = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ptr_q;
    mem_wdata = stat_q & OWN_CLR;
    tx_valid  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (base_upd) ptr_d = base;
        if (poll_go)  state_d = ST_STS;
      end
      ST_STS: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          if (mem_rdata[OWN_BIT]) begin
            stat_d  = mem_rdata;
            rem_d   = mem_rdata[LEN_W-1:0];
            first_d = 1'b1;
            state_d = ST_BLO;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_BLO: begin
        mem_req  = 1'b1;
        mem_addr = ptr_q + OFS_LO;
        if (mem_ack) begin
          buf_d   = {buf_q[ADDR_W-1:32], mem_rdata};
          state_d = ST_BHI;
        end
      end
      ST_BHI: begin
        mem_req  = 1'b1;
        mem_addr = ptr_q + OFS_HI;
        if (mem_ack) begin
          buf_d   = {mem_rdata[ADDR_W-33:0], buf_q[31:0]};
          state_d = (rem_q == '0) ? ST_WB : ST_DAT;
        end
      end
      ST_DAT: begin
        mem_req  = 1'b1;
        mem_addr = {buf_q[ADDR_W-1:2], 2'b00};
        if (mem_ack) begin
          word_d  = mem_rdata;
          state_d = ST_SEND;
        end
      end
      ST_SEND: begin
        tx_valid = 1'b1;
        if (tx_ready) begin
          rem_d   = rem_q - 1'b1;
          buf_d   = buf_q + 1'b1;
          first_d = 1'b0;
          if (rem_q == LEN_W'(1))         state_d = ST_WB;
          else if (buf_q[1:0] == 2'b11)   state_d = ST_DAT;
        end
      end
      ST_WB: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) begin
          done_d  = 1'b1;
          ptr_d   = stat_q[WRAP_BIT] ? base : ptr_q + STEP;
          state_d = ST_STS;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      buf_q   <= '0;
      stat_q  <= '0;
      word_q  <= '0;
      rem_q   <= '0;
      first_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      buf_q   <= buf_d;
      stat_q  <= stat_d;
      word_q  <= word_d;
      rem_q   <= rem_d;
      first_q <= first_d;
      done_q  <= done_d;
    end
  end

  assign cur_word  = word_q;
  assign cur_lane  = buf_q[1:0];
  assign tx_first  = tx_valid & first_q & stat_q[FIRST_BIT];
  assign tx_last   = tx_valid & (rem_q == LEN_W'(1)) & stat_q[LAST_BIT];
  assign desc_done = done_q;
  assign busy      = (state_q != ST_IDLE);

  // R7: the done pulse never lasts two cycles
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    desc_done |=> !desc_done);

  // R9: a stalled byte is held
  a_r9_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(cur_word) && $stable(cur_lane)));

  // R6: a write-back never hands the descriptor to hardware
  a_r6_wb_own_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_wdata[OWN_BIT]);

  // R3: a non-owned status word ends the walk
  a_r3_unowned_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STS && mem_ack && !mem_rdata[OWN_BIT]) |=> !busy);

  // R4: no byte is offered beyond the count
  a_r4_count_left: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (rem_q != '0));
endmodule

// File: rtl/txdesc_poll_engine.sv
module txdesc_poll_engine #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic              base_sel,
  input  logic [31:0]       base_wdata,
  input  logic              poll_we,
  input  logic [7:0]        poll_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  output logic              tx_first,
  output logic              tx_last,
  input  logic              tx_ready,
  output logic              desc_done,
  output logic              busy
);
  localparam int unsigned POLL_BIT = 6;

  logic [ADDR_W-1:0] base;
  logic              base_upd;
  logic              poll_go;
  logic [31:0]       cur_word;
  logic [1:0]        cur_lane;
  logic              unused_poll_bits;

  assign poll_go          = poll_we & poll_data[POLL_BIT];
  assign unused_poll_bits = ^{poll_data[7], poll_data[5:0]};

  txp_ring_base #(.ADDR_W(ADDR_W)) base_i (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (base_we),
    .sel   (base_sel),
    .wdata (base_wdata),
    .base  (base),
    .upd   (base_upd)
  );

  txp_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .poll_go   (poll_go),
    .base      (base),
    .base_upd  (base_upd),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack),
    .cur_word  (cur_word),
    .cur_lane  (cur_lane),
    .tx_valid  (tx_valid),
    .tx_first  (tx_first),
    .tx_last   (tx_last),
    .tx_ready  (tx_ready),
    .desc_done (desc_done),
    .busy      (busy)
  );

  txp_lane_sel #(.LANES(4)) lane_i (
    .word      (cur_word),
    .sel       (cur_lane),
    .lane_byte (tx_data)
  );

  // R2: a poll byte without the start bit leaves the engine idle
  a_r2_poll_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && poll_we && !poll_data[POLL_BIT]) |=> !busy);
endmodule

// File: tb/txdesc_poll_engine_tb_top.sv
module txdesc_poll_engine_tb_top;
  localparam logic [31:0] OWN = 32'h8000_0000;
  localparam logic [31:0] EOR = 32'h4000_0000;
  localparam logic [31:0] FS  = 32'h2000_0000;
  localparam logic [31:0] LS  = 32'h1000_0000;
  localparam int LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0, base_sel = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        poll_we = 1'b0;
  logic [7:0]  poll_data = '0;
  logic        mem_req, mem_we;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        mem_ack;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_first, tx_last;
  logic        tx_ready;
  logic        desc_done, busy;

  always #2 clk = ~clk;

  txdesc_poll_engine dut_i (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_sel(base_sel),
    .base_wdata(base_wdata), .poll_we(poll_we), .poll_data(poll_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_first(tx_first),
    .tx_last(tx_last), .tx_ready(tx_ready), .desc_done(desc_done),
    .busy(busy)
  );

  function automatic logic [7:0] pb(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  // memory model
  logic [31:0] mem [0:1023];
  logic        tb_we = 1'b0;
  logic [9:0]  tb_idx = '0;
  logic [31:0] tb_wdata = '0;
  int          wr_cnt;
  logic        rnd_mode = 1'b0;
  logic [7:0]  lfsr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++)
        mem[i] <= {pb(4*i+3), pb(4*i+2), pb(4*i+1), pb(4*i)};
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      wr_cnt    <= 0;
      lfsr      <= 8'h01;
      tx_ready  <= 1'b1;
    end else begin
      if (tb_we) mem[tb_idx] <= tb_wdata;
      if (mem_req && !mem_ack) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem[mem_addr[11:2]];
        if (mem_we) begin
          mem[mem_addr[11:2]] <= mem_wdata;
          wr_cnt <= wr_cnt + 1;
        end
      end else begin
        mem_ack <= 1'b0;
      end
      lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tx_ready <= rnd_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
    end
  end

  // expected byte stream and port monitor
  logic [7:0] exp_b [0:1023];
  logic       exp_f [0:1023];
  logic       exp_l [0:1023];
  int         exp_n = 0;
  int         rx_idx = 0;
  int         done_cnt = 0;
  int         mon_chk = 0, mon_fail = 0;
  logic       pv = 1'b0, pr = 1'b0, wack = 1'b0;
  logic [7:0] pd = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (wack || desc_done) begin
        mon_chk++;
        if (desc_done !== wack) begin
          mon_fail++;
          $display("FAIL R7 done pulse timing act=%0b exp=%0b", desc_done, wack);
        end
      end
      if (desc_done) done_cnt++;
      if (pv && !pr) begin
        mon_chk++;
        if (!(tx_valid && tx_data == pd)) begin
          mon_fail++;
          $display("FAIL R9 stalled byte act=%0b/%02h exp=1/%02h", tx_valid, tx_data, pd);
        end
      end
      if (tx_valid && tx_ready) begin
        mon_chk++;
        if (rx_idx >= exp_n) begin
          mon_fail++;
          $display("FAIL R4 unexpected byte act=%02h exp=none", tx_data);
        end else if (tx_data !== exp_b[rx_idx] || tx_first !== exp_f[rx_idx] ||
                     tx_last !== exp_l[rx_idx]) begin
          mon_fail++;
          $display("FAIL R4/R5 byte %0d act=%02h f%0b l%0b exp=%02h f%0b l%0b", rx_idx,
                   tx_data, tx_first, tx_last, exp_b[rx_idx], exp_f[rx_idx], exp_l[rx_idx]);
        end
        rx_idx++;
      end
      pv   = tx_valid;
      pr   = tx_ready;
      pd   = tx_data;
      wack = mem_ack && mem_we;
    end
  end

  int chk = 0, fail = 0;
  int cyc = 0;

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    chk++;
    if (!ok) begin
      fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == LIMIT) begin
      $display("FAIL watchdog act=%0d exp=<%0d", cyc, LIMIT);
      $display("%0d/%0d checks passed", chk + mon_chk - fail - mon_fail,
               chk + mon_chk + 1);
      $finish;
    end
  end

  task automatic put_word(input int idx, input logic [31:0] w);
    @(negedge clk);
    tb_we = 1'b1; tb_idx = 10'(idx); tb_wdata = w;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic put_desc(input int addr, input logic [31:0] st, input int bufa);
    put_word(addr/4,     st);
    put_word(addr/4 + 1, 32'h0);
    put_word(addr/4 + 2, 32'(bufa));
    put_word(addr/4 + 3, 32'h0);
  endtask

  task automatic expect_frame(input logic [31:0] st, input int bufa);
    int len = int'(st[15:0]);
    for (int i = 0; i < len; i++) begin
      exp_b[exp_n] = pb(bufa + i);
      exp_f[exp_n] = (i == 0) && st[29];
      exp_l[exp_n] = (i == len - 1) && st[28];
      exp_n++;
    end
  endtask

  task automatic set_base(input logic [31:0] lo, input logic [31:0] hi);
    @(negedge clk); base_we = 1'b1; base_sel = 1'b0; base_wdata = lo;
    @(negedge clk); base_sel = 1'b1; base_wdata = hi;
    @(negedge clk); base_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic poll(input logic [7:0] v);
    @(negedge clk); poll_we = 1'b1; poll_data = v;
    @(negedge clk); poll_we = 1'b0; poll_data = 8'h00;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int d0, w0;
    logic [63:0] a0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!mem_req && !tx_valid && !desc_done && !busy, "R1 idle after reset",
          {mem_req, tx_valid, desc_done, busy}, 0);

    // R2 poll byte without bit 6
    put_desc(0, OWN | EOR | FS | LS | 32'd4, 32'h400);
    poll(8'hBF);
    begin
      int reqs = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (mem_req || busy) reqs++;
      end
      check(reqs == 0, "R2 poll without start bit", reqs, 0);
    end

    // R11 high base half reaches the address
    put_word(16'h100/4, 32'h0);
    set_base(32'h100, 32'h1);
    poll(8'h40);
    a0 = '0;
    for (int i = 0; i < 20 && a0 == 0; i++) begin
      if (mem_req) a0 = mem_addr;
      else @(negedge clk);
    end
    check(a0 == 64'h1_0000_0100, "R11 base halves", a0, 64'h1_0000_0100);
    wait_idle();
    set_base(32'h100, 32'h0);

    // alignment x count sweep: one wrapping descriptor each
    for (int al = 0; al < 4; al++) begin
      for (int len = 0; len < 10; len++) begin
        logic [31:0] st;
        int bufa;
        int k = (len + al) % 4;
        bufa = 32'h800 + 16*len + al;
        st = OWN | EOR | 32'(len) | (k[0] ? FS : 32'h0) | (k[1] ? LS : 32'h0);
        put_desc(32'h100, st, bufa);
        d0 = done_cnt; w0 = wr_cnt;
        expect_frame(st, bufa);
        poll(8'h40);
        wait_idle();
        check(rx_idx == exp_n, $sformatf("R4 R10 count al=%0d len=%0d", al, len), rx_idx, exp_n);
        check(mem[16'h100/4] == (st & ~OWN), "R6 status write-back", mem[16'h100/4], st & ~OWN);
        check(done_cnt - d0 == 1 && wr_cnt - w0 == 1, "R7 R8 one done then wrap",
              done_cnt - d0, 1);
      end
    end

    // ring of three with wrap, random backpressure
    rnd_mode = 1'b1;
    put_desc(32'h100, OWN | FS | LS | 32'd60, 32'h900);
    put_desc(32'h110, OWN | FS | 32'd5, 32'hA03);
    put_desc(32'h120, OWN | EOR | LS | 32'd17, 32'hB01);
    put_desc(32'h130, OWN | FS | LS | 32'd4, 32'hC00);
    expect_frame(OWN | FS | LS | 32'd60, 32'h900);
    expect_frame(OWN | FS | 32'd5, 32'hA03);
    expect_frame(OWN | EOR | LS | 32'd17, 32'hB01);
    d0 = done_cnt;
    poll(8'h40);
    wait_idle();
    check(rx_idx == exp_n, "R4 ring byte count", rx_idx, exp_n);
    check(done_cnt - d0 == 3, "R7 ring done count", done_cnt - d0, 3);
    check(mem[16'h110/4] == (FS | 32'd5), "R8 second slot at +16", mem[16'h110/4], FS | 32'd5);
    check(mem[16'h120/4] == (EOR | LS | 32'd17), "R6 third slot", mem[16'h120/4], EOR | LS | 32'd17);
    check(mem[16'h130/4] == (OWN | FS | LS | 32'd4), "R8 slot past wrap untouched",
          mem[16'h130/4], OWN | FS | LS | 32'd4);
    check(mem[16'h108/4] == 32'h900, "R6 buffer word untouched", mem[16'h108/4], 32'h900);

    // R3 not owned: nothing happens, then resume at the stalled slot
    put_word(16'h100/4, 32'h0000_0005);
    d0 = done_cnt; w0 = wr_cnt;
    poll(8'h40);
    wait_idle();
    check(wr_cnt == w0 && done_cnt == d0 && rx_idx == exp_n, "R3 unowned no action",
          wr_cnt - w0, 0);
    check(mem[16'h100/4] == 32'h5 && !busy, "R3 status kept", mem[16'h100/4], 32'h5);
    put_desc(32'h100, OWN | FS | LS | 32'd3, 32'hC00);
    expect_frame(OWN | FS | LS | 32'd3, 32'hC00);
    d0 = done_cnt;
    poll(8'h40);
    wait_idle();
    check(done_cnt - d0 == 1 && rx_idx == exp_n, "R3 stops at unowned second slot",
          done_cnt - d0, 1);
    put_desc(32'h110, OWN | EOR | FS | LS | 32'd4, 32'hC10);
    expect_frame(OWN | EOR | FS | LS | 32'd4, 32'hC10);
    d0 = done_cnt;
    poll(8'h40);
    wait_idle();
    check(done_cnt - d0 == 1 && rx_idx == exp_n, "R3 R8 resume at stalled slot",
          rx_idx, exp_n);
    check(mem[16'h110/4] == (EOR | FS | LS | 32'd4), "R6 resumed write-back",
          mem[16'h110/4], EOR | FS | LS | 32'd4);
    check(mem[16'h100/4] == (FS | LS | 32'd3), "R8 first slot not refetched as owned",
          mem[16'h100/4], FS | LS | 32'd3);

    $display("%0d/%0d checks passed", chk + mon_chk - fail - mon_fail, chk + mon_chk);
    $finish;
  end
endmodule